// File: doc/BRIEF.md
# Interrupt Enable and Flag Register

This block is the byte-wide interrupt control register of a small microcontroller core. It gathers three interrupt sources: a timer overflow pulse, an already-qualified external interrupt pulse, and a change on any of four watched upper port pins. Each source has an enable bit and a sticky flag bit. A global enable gates all of them into one interrupt request line.

Software reads the whole register at any time and writes it with a single-cycle write strobe. A flag is set by its hardware event whatever the enables hold, and it is cleared only when software writes a zero to it. The four port pins pass through a two-flop synchronizer. The synchronized value is compared each clock against a stored copy, so one pin change gives one set event.

Top module: `intr_ctl_reg`

## Requirements
- R1: The register layout, from bit 7 down to bit 0, is: global enable, reserved, timer enable, external enable, port-change enable, timer flag, external flag, port-change flag. A write stores wr_data into every writable bit at the clock edge, and rd_data shows the register contents directly after that edge.
- R2: Bit 6 cannot be written and always reads 0.
- R3: A timer overflow pulse sampled at a clock edge sets the timer flag (bit 2) at that edge, whatever the enable bits hold.
- R4: An external event pulse sampled at a clock edge sets the external flag (bit 1) at that edge, whatever the enable bits hold.
- R5: A change on any of port_pins[3:0] sets the port-change flag (bit 0) at the third rising edge after the new value is applied. Each change produces exactly one set event.
- R6: A set flag stays set until a write with a 0 in that bit position. Hardware never clears a flag.
- R7: When a hardware event and a write that clears the same flag fall on the same edge, the flag ends up set.
- R8: irq_req is 1 exactly when global enable is 1 and at least one source has both its enable bit and its flag bit at 1.
- R9: After reset, every bit reads 0, except the port-change flag, which takes the value of parameter CHG_FLAG_RST (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| tmr_evt | input | 1 | Timer overflow pulse |
| ext_evt | input | 1 | Qualified external interrupt pulse |
| port_pins | input | 4 | Watched upper port pins, asynchronous |
| irq_req | output | 1 | Interrupt request |

## Verification
All state except the synchronizer pipeline appears directly on rd_data. A wrong flag or enable bit therefore shows on the first read after the faulty edge, and irq_req shows the same fault in the same cycle whenever the global enable is set. A fault in the change detector shows two edges later: a flag that is missing, or a flag that keeps coming back after it is cleared. The bench follows a cycle-exact model of the synchronizer, so any shift in that latency is caught.

// File: rtl/intr_ctl_pkg.sv
package intr_ctl_pkg;

    localparam int REG_W = 8;

    localparam int GIE_B = 7;
    localparam int RSV_B = 6;
    localparam int TEN_B = 5;
    localparam int XEN_B = 4;
    localparam int CEN_B = 3;
    localparam int TFL_B = 2;
    localparam int XFL_B = 1;
    localparam int CFL_B = 0;

    localparam int NUM_SRC = 3;

    typedef struct packed {
        logic gie;
        logic tmr_en;
        logic ext_en;
        logic chg_en;
        logic tmr_fl;
        logic ext_fl;
        logic chg_fl;
    } ctl_reg_t;

    function automatic logic [REG_W-1:0] ctl_pack(input ctl_reg_t r);
        logic [REG_W-1:0] v;
        v        = '0;
        v[GIE_B] = r.gie;
        v[RSV_B] = 1'b0;
        v[TEN_B] = r.tmr_en;
        v[XEN_B] = r.ext_en;
        v[CEN_B] = r.chg_en;
        v[TFL_B] = r.tmr_fl;
        v[XFL_B] = r.ext_fl;
        v[CFL_B] = r.chg_fl;
        return v;
    endfunction

    function automatic ctl_reg_t ctl_unpack(input logic [REG_W-1:0] v);
        ctl_reg_t r;
        r.gie    = v[GIE_B];
        r.tmr_en = v[TEN_B];
        r.ext_en = v[XEN_B];
        r.chg_en = v[CEN_B];
        r.tmr_fl = v[TFL_B];
        r.ext_fl = v[XFL_B];
        r.chg_fl = v[CFL_B];
        return r;
    endfunction

endpackage

// File: rtl/intr_pin_sync.sv
module intr_pin_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[LAST];
endmodule

// File: rtl/intr_chg_detect.sv
module intr_chg_detect #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic         chg_evt
);
    logic [W-1:0] sync_pins;
    logic [W-1:0] prev_d, prev_q;

    intr_pin_sync #(.W(W), .STAGES(STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .dout  (sync_pins)
    );

    always_comb begin
        prev_d  = sync_pins;
        chg_evt = |(sync_pins ^ prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/intr_req_merge.sv
module intr_req_merge #(
    parameter int NSRC = 3
) (
    input  logic            gie,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_fl,
    output logic            irq
);
    logic [NSRC-1:0] pend;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            assign pend[g] = src_en[g] & src_fl[g];
        end
    endgenerate

    assign irq = gie & (|pend);
endmodule

// File: rtl/intr_ctl_reg.sv
module intr_ctl_reg
    import intr_ctl_pkg::*;
#(
    parameter int   PIN_W        = 4,
    parameter int   SYNC_STAGES  = 2,
    parameter logic CHG_FLAG_RST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             tmr_evt,
    input  logic             ext_evt,
    input  logic [PIN_W-1:0] port_pins,
    output logic             irq_req
);
    ctl_reg_t reg_d, reg_q;
    logic     chg_evt;

    intr_chg_detect #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (port_pins),
        .chg_evt (chg_evt)
    );

    // Write first, then OR in hardware sets so an event beats a clearing write.
    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            reg_d = ctl_unpack(wr_data);
        end
        reg_d.tmr_fl = reg_d.tmr_fl | tmr_evt;
        reg_d.ext_fl = reg_d.ext_fl | ext_evt;
        reg_d.chg_fl = reg_d.chg_fl | chg_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q        <= '0;
            reg_q.chg_fl <= CHG_FLAG_RST;
        end else begin
            reg_q <= reg_d;
        end
    end

    intr_req_merge #(.NSRC(NUM_SRC)) i_merge (
        .gie    (reg_q.gie),
        .src_en ({reg_q.tmr_en, reg_q.ext_en, reg_q.chg_en}),
        .src_fl ({reg_q.tmr_fl, reg_q.ext_fl, reg_q.chg_fl}),
        .irq    (irq_req)
    );

    assign rd_data = ctl_pack(reg_q);
endmodule

// File: rtl/intr_ctl_chk.sv
module intr_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       tmr_evt,
    input logic       ext_evt,
    input logic       irq_req
);
    AST_RSVD_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) rd_data[6] == 1'b0); // R2
    AST_TMR_SET:    assert property (@(posedge clk) disable iff (!rst_n) tmr_evt |=> rd_data[2]); // R3
    AST_EXT_SET:    assert property (@(posedge clk) disable iff (!rst_n) ext_evt |=> rd_data[1]); // R4
    AST_EXT_WINS:   assert property (@(posedge clk) disable iff (!rst_n) (wr_en && ext_evt) |=> rd_data[1]); // R7
    AST_FLAG_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (!wr_en && rd_data[2]) |=> rd_data[2]); // R6
    AST_CHG_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (!wr_en && rd_data[0]) |=> rd_data[0]); // R6
    AST_IRQ_GATED:  assert property (@(posedge clk) disable iff (!rst_n) !rd_data[7] |-> !irq_req); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> (|(rd_data[5:3] & rd_data[2:0]))); // R8
endmodule

bind intr_ctl_reg intr_ctl_chk i_intr_ctl_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .tmr_evt (tmr_evt),
    .ext_evt (ext_evt),
    .irq_req (irq_req)
);

// File: tb/test_intr_ctl_reg.sv
module test_intr_ctl_reg;
    localparam int CLK_P    = 10;
    localparam int WDOG_CYC = 100000;
    localparam int N_RAND   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tmr_evt = 1'b0;
    logic       ext_evt = 1'b0;
    logic [3:0] port_pins = '0;
    logic       irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] m_reg;
    logic [3:0] m_s1, m_s2, m_prev;

    always #(CLK_P/2) clk = ~clk;

    intr_ctl_reg i_intr_ctl_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .tmr_evt   (tmr_evt),
        .ext_evt   (ext_evt),
        .port_pins (port_pins),
        .irq_req   (irq_req)
    );

    function automatic logic exp_irq(input logic [7:0] r);
        return r[7] & (|(r[5:3] & r[2:0]));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic t,
                        input logic x, input logic [3:0] p);
        logic chg;
        @(negedge clk);
        wr_en = w; wr_data = d; tmr_evt = t; ext_evt = x; port_pins = p;
        @(posedge clk);
        chg = (m_s2 != m_prev);
        if (w) m_reg = d & 8'hBF;
        m_reg[2] = m_reg[2] | t;
        m_reg[1] = m_reg[1] | x;
        m_reg[0] = m_reg[0] | chg;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = p;
        #1;
    endtask

    task automatic check_model(input string tag);
        check(tag, rd_data, m_reg);
        check({tag, " irq"}, {7'd0, irq_req}, {7'd0, exp_irq(m_reg)});
    endtask

    initial begin : watchdog
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        m_reg = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 reset value", rd_data, 8'h00);
        check("R9 reset irq", {7'd0, irq_req}, 8'h00);

        // R1 / R2: write all ones, reserved stays zero
        step(1'b1, 8'hFF, 1'b0, 1'b0, 4'h0);
        check("R2 reserved reads zero", rd_data, 8'hBF);
        check("R1 write readback", rd_data, m_reg);
        step(1'b1, 8'h00, 1'b0, 1'b0, 4'h0);
        check("R1 clear readback", rd_data, 8'h00);

        // R3 / R4: flags set with all enables off
        step(1'b0, 8'h00, 1'b1, 1'b0, 4'h0);
        check("R3 timer flag with enables off", rd_data, 8'h04);
        step(1'b0, 8'h00, 1'b0, 1'b1, 4'h0);
        check("R4 ext flag with enables off", rd_data, 8'h06);
        check("R8 no irq when gie off", {7'd0, irq_req}, 8'h00);

        // R6: sticky over idle cycles
        repeat (5) step(1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
        check("R6 flags stay set", rd_data, 8'h06);
        step(1'b1, 8'h02, 1'b0, 1'b0, 4'h0);
        check("R6 write zero clears only that flag", rd_data, 8'h02);

        // R7: event beats a clearing write
        step(1'b1, 8'h00, 1'b0, 1'b1, 4'h0);
        check("R7 ext set wins over clear", rd_data, 8'h02);
        step(1'b1, 8'h00, 1'b1, 1'b0, 4'h0);
        check("R7 timer set wins over clear", rd_data, 8'h04);
        step(1'b1, 8'h00, 1'b0, 1'b0, 4'h0);

        // R5: latency and single event
        step(1'b0, 8'h00, 1'b0, 1'b0, 4'h8);
        check("R5 no flag after one edge", rd_data, 8'h00);
        step(1'b0, 8'h00, 1'b0, 1'b0, 4'h8);
        check("R5 no flag after two edges", rd_data, 8'h00);
        step(1'b0, 8'h00, 1'b0, 1'b0, 4'h8);
        check("R5 flag at third edge", rd_data, 8'h01);
        step(1'b1, 8'h00, 1'b0, 1'b0, 4'h8);
        repeat (4) step(1'b0, 8'h00, 1'b0, 1'b0, 4'h8);
        check("R5 one change gives one event", rd_data, 8'h00);

        // R8: request gating
        step(1'b1, 8'h08, 1'b0, 1'b0, 4'h0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
        check("R8 enabled flag without gie", {7'd0, irq_req}, 8'h00);
        step(1'b1, 8'h89, 1'b0, 1'b0, 4'h0);
        check("R8 irq with gie and enabled flag", {7'd0, irq_req}, 8'h01);
        step(1'b1, 8'hB0, 1'b0, 1'b0, 4'h0);
        check("R8 no irq when enabled flags clear", {7'd0, irq_req}, 8'h00);
        step(1'b1, 8'h87, 1'b0, 1'b0, 4'h0);
        check("R8 no irq when flags not enabled", {7'd0, irq_req}, 8'h00);
        step(1'b1, 8'h00, 1'b0, 1'b0, 4'h0);

        // Random mix against model (R1, R3..R8)
        for (int i = 0; i < N_RAND; i++) begin
            logic       w, t, x;
            logic [7:0] d;
            logic [3:0] p;
            w = ($urandom % 4) == 0;
            d = 8'($urandom);
            t = ($urandom % 8) == 0;
            x = ($urandom % 8) == 0;
            p = port_pins;
            if (($urandom % 6) == 0) p = p ^ 4'($urandom);
            step(w, d, t, x, p);
            check_model("R1 R8 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule